// File: doc/BRIEF.md
# UART Software Flow Controller

This block handles automatic in-band flow control for a UART. It sits between the receive deserializer, the receive FIFO and the transmit serializer. It inspects every received character and compares it with four programmable flow characters: two resume characters and two pause characters. A matched pause character stops host data from reaching the transmitter. A matched resume character lets host data through again. Matched flow characters are removed from the receive stream. All other characters are written to the FIFO.

The block also watches the receive FIFO occupancy. When occupancy climbs to a programmable halt threshold, it sends the pause character(s) to the remote end. When occupancy drains to a resume threshold, it sends the resume character(s). These injected characters pre-empt host data at the next character boundary.

Matching and injection work either on single characters or on two-character sequences. A pause match can also raise a status flag and an interrupt.

Top module: `sw_flow_ctrl`

## Requirements
- R1: After reset, all four flow character registers hold 0x00, host traffic is not suspended, nothing is injected, and `xoff_flag_o` and `irq_o` are low.
- R2: A write with `reg_we_i` high loads `reg_wdata_i` into the flow character register chosen by `reg_sel_i`: 0 selects resume-1, 1 selects resume-2, 2 selects pause-1 and 3 selects pause-2.
- R3: In single mode (`dbl_i` low), each received character is compared with pause-1 and resume-1. If both registers hold the same value, the pause match wins.
- R4: A pause match suspends host traffic from the next cycle on: `tx_valid_o` stays low for host data and `host_ready_o` stays low. A character the transmitter has already accepted is unaffected.
- R5: A resume match ends a suspension and clears `xoff_flag_o`.
- R6: If `irq_en_i` is high, a pause match sets `xoff_flag_o`, and `irq_o` follows it. If `irq_en_i` is low, a pause match leaves both low.
- R7: Matched flow characters are never written to the FIFO. Any other character appears on `fifo_we_o`/`fifo_wdata_o` one cycle after its strobe.
- R8: In double mode, two consecutive received characters must equal pause-1 then pause-2, or resume-1 then resume-2. If the second character does not match, the held first character is written to the FIFO. The new character is then either held as a new first character or written in the following cycle. Receive strobes are at least two cycles apart.
- R9: With a non-zero `halt_lvl_i`, occupancy reaching 4×`halt_lvl_i` injects the pause character(s) once. Occupancy then falling to 4×`resume_lvl_i` or below injects the resume character(s) once. In double mode, both characters of the pair are sent. A zero halt level disables injection.
- R10: An injected character is presented on `tx_valid_o`/`tx_data_o` ahead of host data, even while host traffic is suspended. It is held there until `tx_ready_i` accepts it.
- R11: With `en_i` low, every received character passes to the FIFO, no suspension applies, and nothing is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables flow control |
| dbl_i | input | 1 | Two-character mode |
| irq_en_i | input | 1 | Enables the pause-match flag and interrupt |
| halt_lvl_i | input | 4 | Halt threshold in units of four entries |
| resume_lvl_i | input | 4 | Resume threshold in units of four entries |
| reg_we_i | input | 1 | Flow character register write strobe |
| reg_sel_i | input | 2 | Flow character register select |
| reg_wdata_i | input | 8 | Flow character write data |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| fifo_we_o | output | 1 | Receive FIFO write |
| fifo_wdata_o | output | 8 | Receive FIFO write data |
| fifo_level_i | input | 7 | Receive FIFO occupancy |
| host_valid_i | input | 1 | Host has a character to send |
| host_data_i | input | 8 | Host character |
| host_ready_o | output | 1 | Host character accepted |
| tx_valid_o | output | 1 | Character offered to the transmitter |
| tx_data_o | output | 8 | Character to transmit |
| tx_ready_i | input | 1 | Transmitter accepts a character |
| xoff_flag_o | output | 1 | Pause-match status flag |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions check several rules on every cycle:
- A suspension starts only on a pause match, and ends only on a resume match or when flow control is disabled.
- The status flag rises only on a pause match with the interrupt enabled.
- Threshold throttling starts only at or above the halt level.
- An injected character stays put until accepted, and a single injection ends after one handshake.
- Matched characters produce no FIFO write, and receive strobes keep their spacing.

Only the bench scenarios can show the rest: which byte values pass through, the release order of a held character after a broken pair, the exact character order of injected pairs, one injection per threshold crossing, the reset contents of the character registers, and pass-through when disabled.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic {FC_XON = 1'b0, FC_XOFF = 1'b1} fc_kind_e;
  localparam int unsigned NUM_CHR  = 4;
  localparam int unsigned SEL_XON1  = 0;
  localparam int unsigned SEL_XON2  = 1;
  localparam int unsigned SEL_XOFF1 = 2;
  localparam int unsigned SEL_XOFF2 = 3;
  localparam int unsigned LVL_SH   = 2;  // threshold unit = 4 entries
endpackage

// File: rtl/sfc_matcher.sv
module sfc_matcher
  import sfc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dbl_i,
  input  logic [DW-1:0] xon1_i,
  input  logic [DW-1:0] xon2_i,
  input  logic [DW-1:0] xoff1_i,
  input  logic [DW-1:0] xoff2_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          hit_xon_o,
  output logic          hit_xoff_o,
  output logic          fifo_we_o,
  output logic [DW-1:0] fifo_wdata_o
);
  logic          held_q, spill_q;
  fc_kind_e      held_kind_q, new_kind;
  logic [DW-1:0] held_data_q, spill_data_q;
  logic          first_off, first_on, second_ok;
  logic          we_d, hold_set, hold_clr, spill_set;
  logic [DW-1:0] wd_d;

  assign first_off = (rx_data_i == xoff1_i);
  assign first_on  = (rx_data_i == xon1_i);
  assign new_kind  = first_off ? FC_XOFF : FC_XON;
  assign second_ok = (rx_data_i == ((held_kind_q == FC_XOFF) ? xoff2_i : xon2_i));

  always_comb begin
    hit_xon_o  = 1'b0;
    hit_xoff_o = 1'b0;
    we_d       = spill_q;
    wd_d       = spill_q ? spill_data_q : rx_data_i;
    hold_set   = 1'b0;
    hold_clr   = 1'b0;
    spill_set  = 1'b0;
    if (rx_valid_i) begin
      wd_d = rx_data_i;
      if (!en_i) begin
        we_d = 1'b1;
      end else if (!dbl_i) begin
        if (first_off)     hit_xoff_o = 1'b1;
        else if (first_on) hit_xon_o  = 1'b1;
        else               we_d       = 1'b1;
      end else if (!held_q) begin
        if (first_off || first_on) hold_set = 1'b1;
        else                       we_d     = 1'b1;
      end else if (second_ok) begin
        hold_clr = 1'b1;
        if (held_kind_q == FC_XOFF) hit_xoff_o = 1'b1;
        else                        hit_xon_o  = 1'b1;
      end else begin
        // broken pair: release held char, reconsider the new one
        we_d     = 1'b1;
        wd_d     = held_data_q;
        hold_clr = 1'b1;
        if (first_off || first_on) hold_set  = 1'b1;
        else                       spill_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_we_o    <= 1'b0;
      fifo_wdata_o <= '0;
      held_q       <= 1'b0;
      held_kind_q  <= FC_XON;
      held_data_q  <= '0;
      spill_q      <= 1'b0;
      spill_data_q <= '0;
    end else begin
      fifo_we_o <= we_d;
      if (we_d) fifo_wdata_o <= wd_d;
      spill_q <= spill_set;
      if (spill_set) spill_data_q <= rx_data_i;
      if (!en_i || !dbl_i) begin
        held_q <= 1'b0;
      end else if (hold_set) begin
        held_q      <= 1'b1;
        held_kind_q <= new_kind;
        held_data_q <= rx_data_i;
      end else if (hold_clr) begin
        held_q <= 1'b0;
      end
    end
  end

  a_r8_rx_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_q |-> !rx_valid_i);
  a_r7_no_write_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_xon_o || hit_xoff_o) |=> !fifo_we_o);
endmodule

// File: rtl/sfc_injector.sv
module sfc_injector
  import sfc_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned FILL_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dbl_i,
  input  logic [LVL_W-1:0]  halt_lvl_i,
  input  logic [LVL_W-1:0]  resume_lvl_i,
  input  logic [FILL_W-1:0] fifo_level_i,
  input  logic [DW-1:0]     xon1_i,
  input  logic [DW-1:0]     xon2_i,
  input  logic [DW-1:0]     xoff1_i,
  input  logic [DW-1:0]     xoff2_i,
  input  logic              tx_ready_i,
  output logic              inj_valid_o,
  output logic [DW-1:0]     inj_data_o
);
  logic              pend_q, idx_q, thr_q, take, halt_on;
  fc_kind_e          kind_q;
  logic [FILL_W-1:0] halt_thr, res_thr;

  assign halt_thr = FILL_W'({halt_lvl_i, {LVL_SH{1'b0}}});
  assign res_thr  = FILL_W'({resume_lvl_i, {LVL_SH{1'b0}}});
  assign halt_on  = (halt_lvl_i != '0);
  assign take     = pend_q && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      idx_q  <= 1'b0;
      thr_q  <= 1'b0;
      kind_q <= FC_XON;
    end else if (!en_i) begin
      pend_q <= 1'b0;
      idx_q  <= 1'b0;
      thr_q  <= 1'b0;
    end else if (pend_q) begin
      if (take) begin
        if (dbl_i && !idx_q) begin
          idx_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
          idx_q  <= 1'b0;
        end
      end
    end else if (!thr_q && halt_on && fifo_level_i >= halt_thr) begin
      pend_q <= 1'b1;
      kind_q <= FC_XOFF;
      thr_q  <= 1'b1;
    end else if (thr_q && fifo_level_i <= res_thr) begin
      pend_q <= 1'b1;
      kind_q <= FC_XON;
      thr_q  <= 1'b0;
    end
  end

  assign inj_valid_o = pend_q;
  always_comb begin
    unique case ({kind_q == FC_XOFF, idx_q})
      2'b00:   inj_data_o = xon1_i;
      2'b01:   inj_data_o = xon2_i;
      2'b10:   inj_data_o = xoff1_i;
      default: inj_data_o = xoff2_i;
    endcase
  end

  a_r9_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(thr_q) |-> $past(halt_lvl_i != '0 && fifo_level_i >= halt_thr));
  a_r9_single_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && en_i && !dbl_i) |=> !pend_q);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !tx_ready_i && en_i) |=> pend_q);
endmodule

// File: rtl/sw_flow_ctrl.sv
module sw_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned FILL_W = 7,
  localparam int unsigned SEL_W = $clog2(NUM_CHR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dbl_i,
  input  logic              irq_en_i,
  input  logic [LVL_W-1:0]  halt_lvl_i,
  input  logic [LVL_W-1:0]  resume_lvl_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              rx_valid_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              fifo_we_o,
  output logic [DW-1:0]     fifo_wdata_o,
  input  logic [FILL_W-1:0] fifo_level_i,
  input  logic              host_valid_i,
  input  logic [DW-1:0]     host_data_i,
  output logic              host_ready_o,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  input  logic              tx_ready_i,
  output logic              xoff_flag_o,
  output logic              irq_o
);
  logic [DW-1:0] chr_q [NUM_CHR];
  logic          hit_xon, hit_xoff, susp_q, flag_q, inj_valid;
  logic [DW-1:0] inj_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CHR; i++) chr_q[i] <= '0;
    end else if (reg_we_i) begin
      for (int i = 0; i < NUM_CHR; i++)
        if (reg_sel_i == SEL_W'(i)) chr_q[i] <= reg_wdata_i;
    end
  end

  sfc_matcher #(.DW(DW)) u_match (
    .clk_i, .rst_ni, .en_i, .dbl_i,
    .xon1_i (chr_q[SEL_XON1]), .xon2_i (chr_q[SEL_XON2]),
    .xoff1_i(chr_q[SEL_XOFF1]), .xoff2_i(chr_q[SEL_XOFF2]),
    .rx_valid_i, .rx_data_i,
    .hit_xon_o(hit_xon), .hit_xoff_o(hit_xoff),
    .fifo_we_o, .fifo_wdata_o
  );

  sfc_injector #(.DW(DW), .LVL_W(LVL_W), .FILL_W(FILL_W)) u_inj (
    .clk_i, .rst_ni, .en_i, .dbl_i, .halt_lvl_i, .resume_lvl_i, .fifo_level_i,
    .xon1_i (chr_q[SEL_XON1]), .xon2_i (chr_q[SEL_XON2]),
    .xoff1_i(chr_q[SEL_XOFF1]), .xoff2_i(chr_q[SEL_XOFF2]),
    .tx_ready_i,
    .inj_valid_o(inj_valid), .inj_data_o(inj_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (!en_i) begin
      susp_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (hit_xoff) begin
      susp_q <= 1'b1;
      if (irq_en_i) flag_q <= 1'b1;
    end else if (hit_xon) begin
      susp_q <= 1'b0;
      flag_q <= 1'b0;
    end
  end

  // injected chars pre-empt host data and bypass suspension
  assign tx_valid_o   = inj_valid || (host_valid_i && !susp_q);
  assign tx_data_o    = inj_valid ? inj_data : host_data_i;
  assign host_ready_o = tx_ready_i && !inj_valid && !susp_q;
  assign xoff_flag_o  = flag_q;
  assign irq_o        = flag_q && irq_en_i;

  a_r4_suspend_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_q) |-> $past(hit_xoff));
  a_r5_resume_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_q) |-> $past(hit_xon || !en_i));
  a_r6_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xoff_flag_o) |-> $past(hit_xoff && irq_en_i));
  a_r10_inj_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid |-> (tx_valid_o && !host_ready_o));
endmodule

// File: tb/tb_sw_flow_ctrl.sv
module tb_sw_flow_ctrl;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic en = 0, dbl = 0, irq_en = 0;
  logic [3:0] halt_lvl = 0, resume_lvl = 0;
  logic reg_we = 0; logic [1:0] reg_sel = 0; logic [7:0] reg_wdata = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0;
  logic fifo_we; logic [7:0] fifo_wdata; logic [6:0] fifo_level = 0;
  logic host_valid = 0; logic [7:0] host_data = 8'h55;
  logic host_ready, tx_valid, tx_ready = 0, xoff_flag, irq;
  logic [7:0] tx_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sw_flow_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dbl_i(dbl), .irq_en_i(irq_en),
    .halt_lvl_i(halt_lvl), .resume_lvl_i(resume_lvl),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .fifo_we_o(fifo_we), .fifo_wdata_o(fifo_wdata), .fifo_level_i(fifo_level),
    .host_valid_i(host_valid), .host_data_i(host_data), .host_ready_o(host_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .xoff_flag_o(xoff_flag), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  // strobe one byte; returns at the negedge after the capturing edge
  task automatic rx(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic level(input logic [6:0] l);
    @(negedge clk); fifo_level = l;
    @(negedge clk);
  endtask

  // {rx byte, exp fifo_we, exp fifo data, exp host tx_valid}; single mode, xon1=11 xoff1=13
  localparam logic [17:0] VEC [7] = '{
    {8'h41, 1'b1, 8'h41, 1'b1},
    {8'h13, 1'b0, 8'h00, 1'b0},
    {8'h42, 1'b1, 8'h42, 1'b0},
    {8'h13, 1'b0, 8'h00, 1'b0},
    {8'h11, 1'b0, 8'h00, 1'b1},
    {8'h11, 1'b0, 8'h00, 1'b1},
    {8'h5A, 1'b1, 8'h5A, 1'b1}
  };

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid == 0 && irq == 0 && fifo_we == 0 && xoff_flag == 0, "R1 reset outputs",
          {tx_valid, irq, fifo_we, xoff_flag}, 0);
    rst_n = 1;
    en = 1; host_valid = 1;
    @(negedge clk);
    check(tx_valid == 1, "R1 not suspended after reset", tx_valid, 1);
    rx(8'h00);  // all registers 0x00 -> pause match
    check(fifo_we == 0 && tx_valid == 0, "R1 regs reset to 00", {fifo_we, tx_valid}, 0);
    wr(2'd0, 8'h11);
    rx(8'h11);
    check(tx_valid == 1 && fifo_we == 0, "R2 resume-1 written at sel 0", {fifo_we, tx_valid}, 1);
    wr(2'd2, 8'h13); wr(2'd1, 8'h12); wr(2'd3, 8'h14);

    for (int i = 0; i < 7; i++) begin
      rx(VEC[i][17:10]);
      check(fifo_we == VEC[i][9] && (!VEC[i][9] || fifo_wdata == VEC[i][8:1]) && tx_valid == VEC[i][0],
            $sformatf("R3 R4 R5 R7 vector %0d", i),
            {fifo_we, fifo_wdata, tx_valid}, {VEC[i][9], VEC[i][9] ? VEC[i][8:1] : fifo_wdata, VEC[i][0]});
    end

    // R4: transmitter ready, host blocked while suspended
    tx_ready = 1;
    @(negedge clk);
    check(host_ready == 1, "R4 host accepted when running", host_ready, 1);
    rx(8'h13);
    check(host_ready == 0 && tx_valid == 0, "R4 host blocked at boundary", {host_ready, tx_valid}, 0);
    rx(8'h11);
    tx_ready = 0;

    // R6 interrupt
    irq_en = 1;
    rx(8'h13);
    check(irq == 1 && xoff_flag == 1, "R6 flag and irq on pause", {irq, xoff_flag}, 3);
    rx(8'h11);
    check(irq == 0 && xoff_flag == 0, "R5 flag cleared on resume", {irq, xoff_flag}, 0);
    irq_en = 0;
    rx(8'h13);
    check(irq == 0 && xoff_flag == 0, "R6 no flag when disabled", {irq, xoff_flag}, 0);
    rx(8'h11);

    // R8 double mode
    dbl = 1;
    rx(8'h13); rx(8'h14);
    check(fifo_we == 0 && tx_valid == 0, "R8 pair pauses, not written", {fifo_we, tx_valid}, 0);
    rx(8'h11); rx(8'h12);
    check(fifo_we == 0 && tx_valid == 1, "R8 pair resumes", {fifo_we, tx_valid}, 1);
    rx(8'h13); rx(8'h41);
    check(fifo_we == 1 && fifo_wdata == 8'h13, "R8 held char released", fifo_wdata, 8'h13);
    @(negedge clk);
    check(fifo_we == 1 && fifo_wdata == 8'h41, "R8 mismatching char follows", fifo_wdata, 8'h41);
    rx(8'h13); rx(8'h14);
    rx(8'h13); rx(8'h11);
    check(fifo_we == 1 && fifo_wdata == 8'h13, "R8 release then re-hold", fifo_wdata, 8'h13);
    rx(8'h12);
    check(fifo_we == 0 && tx_valid == 1, "R8 re-held first completes pair", {fifo_we, tx_valid}, 1);

    // R9/R10 injection, single mode
    dbl = 0; halt_lvl = 2; resume_lvl = 1;
    level(7);
    check(tx_data == 8'h55, "R9 below halt no injection", tx_data, 8'h55);
    level(8);
    check(tx_valid == 1 && tx_data == 8'h13, "R9 pause injected at halt", tx_data, 8'h13);
    tx_ready = 1;
    #1;
    check(host_ready == 0, "R10 injected ahead of host", host_ready, 0);
    @(negedge clk);
    check(tx_data == 8'h55 && host_ready == 1, "R9 single pause sent", tx_data, 8'h55);
    @(negedge clk);
    check(tx_data == 8'h55, "R9 once per crossing", tx_data, 8'h55);
    level(5);
    check(tx_data == 8'h55, "R9 above resume no injection", tx_data, 8'h55);
    level(4);
    check(tx_data == 8'h11, "R9 resume injected", tx_data, 8'h11);
    @(negedge clk);

    // double-mode injection
    dbl = 1;
    level(8);
    check(tx_data == 8'h13, "R9 pair first", tx_data, 8'h13);
    @(negedge clk);
    check(tx_data == 8'h14, "R9 pair second", tx_data, 8'h14);
    @(negedge clk);
    check(tx_data == 8'h55, "R9 pair done", tx_data, 8'h55);
    level(0);
    check(tx_data == 8'h11, "R9 resume pair first", tx_data, 8'h11);
    @(negedge clk);
    check(tx_data == 8'h12, "R9 resume pair second", tx_data, 8'h12);
    @(negedge clk);

    // zero halt level disables
    halt_lvl = 0;
    level(40);
    check(tx_data == 8'h55, "R9 zero halt disables", tx_data, 8'h55);
    level(0);

    // R10 injection while suspended
    dbl = 0; halt_lvl = 2; tx_ready = 0;
    rx(8'h13);
    level(8);
    check(tx_valid == 1 && tx_data == 8'h13, "R10 injection bypasses suspension", tx_data, 8'h13);
    tx_ready = 1;
    @(negedge clk);
    check(tx_valid == 0, "R10 host still blocked after injection", tx_valid, 0);
    tx_ready = 0;
    level(0);
    rx(8'h11);

    // R11 disabled pass-through
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    en = 0;
    rx(8'h13);
    check(fifo_we == 1 && fifo_wdata == 8'h13 && tx_valid == 1, "R11 pass-through when disabled",
          {fifo_we, fifo_wdata, tx_valid}, {1'b1, 8'h13, 1'b1});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule